// File: doc/BRIEF.md
# Mode-Switched Interrupt Controller Clock Divider

This block produces the slow clock for an interrupt controller by dividing the CPU clock. It does not run from a second oscillator. The divide ratio follows the CPU frequency mode: 8 in the fast (133 MHz) mode and 6 in the slow (100 MHz) mode. Either way the output sits near 16.67 MHz.

Every output edge is launched by a rising edge of the CPU clock through a final register. The output therefore follows the CPU clock with a fixed, bounded lag. The analog trimming of that lag is not part of this block. The mode input is read only when a new output period begins, so a mode change never cuts a period short or stretches it.

Top module: `irq_clk_divider`

## Requirements
- R1: With `fast_mode_i` = 1, each output period lasts 8 `clk_i` cycles: 4 cycles high, then 4 cycles low.
- R2: With `fast_mode_i` = 0, each output period lasts 6 `clk_i` cycles: 3 cycles high, then 3 cycles low.
- R3: `fast_mode_i` is sampled only on the `clk_i` rising edge that starts a period. A change during a period leaves the high and low lengths of that period as they were, and it applies from the next period on.
- R4: `rst_ni` low asynchronously forces `clk_o` low and clears the divider state. `clk_o` stays low while `rst_ni` is held low, whatever `fast_mode_i` does.
- R5: `clk_o` is high after the first `clk_i` rising edge that follows reset release. That period uses the ratio selected by `fast_mode_i` at that edge.
- R6: `clk_o` changes only on `clk_i` rising edges. No high or low phase is ever longer than 4 cycles or shorter than 3 cycles, including across mode changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_mode_i | input | 1 | 1 selects divide by 8, 0 selects divide by 6 |
| clk_o | output | 1 | Divided, registered clock output |

## Verification
The bound checker runs on every cycle. It checks that each high phase and each low phase has the length set by the mode captured at the start of its period. It checks that no phase leaves the 3-to-4 cycle range, and that the output is high right after the first edge following reset.

The asynchronous effect of reset can only be shown by the bench's scenarios: the output drops in the middle of a high phase and stays low while the mode input toggles during reset. The bench scenarios also show that a mode change made in the middle of a period is held back until the next period.

// File: rtl/irq_div_pkg.sv
package irq_div_pkg;
  localparam int unsigned DIV_FAST_DEF = 8;
  localparam int unsigned DIV_SLOW_DEF = 6;

  function automatic int unsigned div_max(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/irq_div_ratio_sel.sv
module irq_div_ratio_sel #(
  parameter int unsigned DIV_FAST = 8,
  parameter int unsigned DIV_SLOW = 6,
  parameter int unsigned CNT_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fast_mode_i,
  input  logic             period_start_i,
  output logic [CNT_W-1:0] ratio_o
);
  localparam logic [CNT_W-1:0] RatioFast = CNT_W'(DIV_FAST);
  localparam logic [CNT_W-1:0] RatioSlow = CNT_W'(DIV_SLOW);

  logic [CNT_W-1:0] ratio_q, ratio_req;

  assign ratio_req = fast_mode_i ? RatioFast : RatioSlow;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ratio_q <= RatioFast;
    else if (period_start_i) ratio_q <= ratio_req;
  end

  // new request is honoured only in the first cycle of a period
  assign ratio_o = period_start_i ? ratio_req : ratio_q;
endmodule

// File: rtl/irq_div_counter.sv
module irq_div_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] ratio_i,
  output logic             period_start_o,
  output logic             high_phase_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] half;

  assign half           = ratio_i >> 1;
  assign period_start_o = (cnt_q == '0);
  assign high_phase_o   = (cnt_q < half);
  assign cnt_d          = (cnt_q == ratio_i - CNT_W'(1)) ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/irq_div_out_reg.sv
module irq_div_out_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/irq_clk_divider.sv
module irq_clk_divider #(
  parameter int unsigned DIV_FAST = irq_div_pkg::DIV_FAST_DEF,
  parameter int unsigned DIV_SLOW = irq_div_pkg::DIV_SLOW_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_mode_i,
  output logic clk_o
);
  localparam int unsigned DIV_MAX = irq_div_pkg::div_max(DIV_FAST, DIV_SLOW);
  localparam int unsigned CNT_W   = $clog2(DIV_MAX + 1);

  logic [CNT_W-1:0] ratio;
  logic             period_start;
  logic             high_phase;

  irq_div_ratio_sel #(
    .DIV_FAST(DIV_FAST),
    .DIV_SLOW(DIV_SLOW),
    .CNT_W   (CNT_W)
  ) u_ratio (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fast_mode_i   (fast_mode_i),
    .period_start_i(period_start),
    .ratio_o       (ratio)
  );

  irq_div_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ratio_i       (ratio),
    .period_start_o(period_start),
    .high_phase_o  (high_phase)
  );

  irq_div_out_reg u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (high_phase),
    .q_o   (clk_o)
  );
endmodule

// File: rtl/irq_clk_divider_chk.sv
module irq_clk_divider_chk #(
  parameter int unsigned DIV_FAST = 8,
  parameter int unsigned DIV_SLOW = 6
) (
  input logic clk_i,
  input logic rst_ni,
  input logic fast_mode_i,
  input logic clk_o
);
  localparam int unsigned HALF_F = DIV_FAST / 2;
  localparam int unsigned HALF_S = DIV_SLOW / 2;
  localparam int unsigned HALF_MAX = (HALF_F > HALF_S) ? HALF_F : HALF_S;
  localparam int unsigned HALF_MIN = (HALF_F < HALF_S) ? HALF_F : HALF_S;
  localparam int unsigned RUN_W  = $clog2(DIV_FAST + DIV_SLOW + 2);
  localparam logic [RUN_W-1:0] RUN_SAT = {RUN_W{1'b1}};

  logic [RUN_W-1:0] hi_run, lo_run, half_q;
  logic             clk_d, mode_d, full_q;
  logic [1:0]       age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run <= '0;
      lo_run <= '0;
      half_q <= RUN_W'(HALF_F);
      clk_d  <= 1'b0;
      mode_d <= 1'b0;
      full_q <= 1'b0;
      age_q  <= '0;
    end else begin
      clk_d  <= clk_o;
      mode_d <= fast_mode_i;
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
      if (clk_o) begin
        lo_run <= '0;
        if (hi_run != RUN_SAT) hi_run <= hi_run + RUN_W'(1);
      end else begin
        hi_run <= '0;
        if (lo_run != RUN_SAT) lo_run <= lo_run + RUN_W'(1);
      end
      if (clk_o && !clk_d) half_q <= mode_d ? RUN_W'(HALF_F) : RUN_W'(HALF_S);
      if (!clk_o && clk_d) full_q <= 1'b1;
    end
  end

  // R2 and R3 also: high length matches the mode seen at period start
  assert_high_len_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_o && clk_d) |-> (hi_run == half_q));

  assert_low_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_o && !clk_d && full_q) |-> (lo_run == half_q));

  assert_first_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd1) |-> clk_o);

  assert_run_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_run <= RUN_W'(HALF_MAX)) && (lo_run <= RUN_W'(HALF_MAX)));

  assert_run_min_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_o && clk_d) |-> (hi_run >= RUN_W'(HALF_MIN)));
endmodule

bind irq_clk_divider irq_clk_divider_chk #(
  .DIV_FAST(DIV_FAST),
  .DIV_SLOW(DIV_SLOW)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fast_mode_i(fast_mode_i),
  .clk_o      (clk_o)
);

// File: tb/irq_clk_divider_tb_top.sv
module irq_clk_divider_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic fast_mode_i = 1'b1;
  logic clk_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  irq_clk_divider dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fast_mode_i(fast_mode_i),
    .clk_o      (clk_o)
  );

  // {mode, expected high, expected low}
  localparam int NVEC = 6;
  localparam int VEC [NVEC][3] = '{
    '{1, 4, 4}, '{0, 3, 3}, '{0, 3, 3}, '{1, 4, 4}, '{0, 3, 3}, '{1, 4, 4}
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic sync_high();
    do @(negedge clk_i); while (clk_o !== 1'b0);
    do @(negedge clk_i); while (clk_o !== 1'b1);
  endtask

  task automatic count_period(output int hi, output int lo);
    hi = 0;
    lo = 0;
    while (clk_o === 1'b1) begin hi++; @(negedge clk_i); end
    while (clk_o === 1'b0) begin lo++; @(negedge clk_i); end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int hi, lo;
    // R4: output low while in reset
    repeat (3) @(negedge clk_i);
    chk("R4 reset low", int'(clk_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R5 first edge high", int'(clk_o), 1);

    // table walk: R1 (mode 1) and R2 (mode 0)
    for (int i = 0; i < NVEC; i++) begin
      fast_mode_i = VEC[i][0][0];
      sync_high();
      count_period(hi, lo);
      chk(VEC[i][0] != 0 ? "R1 high" : "R2 high", hi, VEC[i][1]);
      chk(VEC[i][0] != 0 ? "R1 low"  : "R2 low",  lo, VEC[i][2]);
    end

    // R3: mid-period change fast->slow held back
    fast_mode_i = 1'b1;
    sync_high();
    count_period(hi, lo);
    sync_high();
    fast_mode_i = 1'b0;
    count_period(hi, lo);
    chk("R3 fast kept high", hi, 4);
    chk("R3 fast kept low", lo, 4);
    count_period(hi, lo);
    chk("R3 slow next high", hi, 3);
    chk("R3 slow next low", lo, 3);

    // R3: mid-period change slow->fast held back, changed in low phase
    sync_high();
    @(negedge clk_i); @(negedge clk_i); @(negedge clk_i);
    fast_mode_i = 1'b1;
    @(negedge clk_i);
    chk("R3 slow kept low phase", int'(clk_o), 0);
    @(negedge clk_i);
    chk("R3 slow kept low end", int'(clk_o), 0);
    @(negedge clk_i);
    chk("R3 new period on time", int'(clk_o), 1);
    count_period(hi, lo);
    chk("R3 fast next high", hi, 4);
    chk("R3 fast next low", lo, 4);

    // R4: async reset during high phase, mode toggling while held
    sync_high();
    #1 rst_ni = 1'b0;
    #1 chk("R4 async drop", int'(clk_o), 0);
    for (int k = 0; k < 4; k++) begin
      fast_mode_i = ~fast_mode_i;
      @(negedge clk_i);
      chk("R4 held low", int'(clk_o), 0);
    end
    fast_mode_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R5 high after release", int'(clk_o), 1);
    count_period(hi, lo);
    chk("R5 ratio at release high", hi, 3);
    chk("R5 ratio at release low", lo, 3);

    // R6: alternate mode each period, phases stay within 3..4
    for (int k = 0; k < 6; k++) begin
      fast_mode_i = ~fast_mode_i;
      sync_high();
      count_period(hi, lo);
      chk("R6 high in range", int'(hi >= 3 && hi <= 4), 1);
      chk("R6 low matches high", lo, hi);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule